// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the device-side read path of a page-organised serial flash. A host drives chip select, serial clock and serial data in. The block decodes an 8-bit command and a 24-bit address, then streams bytes from an internal array out on the serial data output, most significant bit first. Two read commands are served. The stream command walks across page boundaries and wraps around the whole array. The page command first swallows four padding bytes and then circles inside one page.

The array is a register memory of `PAGES` pages with a stride of 264 bytes. A geometry pin selects how the address is split and how long a page is. In the long geometry a page holds 264 bytes. In the binary geometry a page holds 256 bytes, and the last eight slots of each stride go unused. Since no write commands are in scope, every location is loaded at reset from a fixed fill pattern. All inputs are sampled in the block's own clock domain: the serial clock is oversampled, and its edges are found by comparison with its value one cycle earlier.

Top module: `serial_flash_reader`

## Requirements
- R1: Command byte 0x03 (the stream command) is followed by exactly 24 address bits and no padding. The first data bit appears on `so` after the falling serial-clock edge that follows the 32nd rising edge of the command.
- R2: Command byte 0xD2 (the page command) is followed by 24 address bits and then 32 ignored bits. The first data bit appears after the falling edge that follows the 64th rising edge, and `so_oe` stays low through all command, address and padding bits.
- R3: With `page_bin`=0 the page is address bits [19:9] modulo `PAGES` and the start column is bits [8:0]. A start column of 264 to 511 is reduced by 264.
- R4: With `page_bin`=1 the page is address bits [18:8] modulo `PAGES`, the start column is bits [7:0], and a page holds 256 bytes.
- R5: Under the stream command, reading past the last column of a page continues at column 0 of the next page, with no extra clock pulses.
- R6: Under the stream command, reading past the last column of page `PAGES`-1 continues at column 0 of page 0, with no extra clock pulses.
- R7: Under the page command, reading past the last column of the page continues at column 0 of the same page.
- R8: Input bits are taken on rising serial-clock edges, MSB first. `so` changes only after falling edges, and it holds steady while the serial clock is high.
- R9: When `cs_n` goes high, `so_oe` drops in the same cycle and the command ends. The next low period starts a fresh command at bit 0.
- R10: Any other command byte keeps `so_oe` low for the rest of the chip-select low period, and the serial clock is ignored until `cs_n` rises.
- R11: Page p, column c sits at linear index i = p*264 + c, and its byte is ((7*i + floor(i/256)) mod 256) XOR 0xC3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; oversamples the serial inputs |
| rst_n | input | 1 | Synchronous active-low reset; loads the array fill pattern |
| page_bin | input | 1 | Geometry select: 0 = 264-byte pages, 1 = 256-byte pages |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
The assertions assume that `sck`, `si` and `cs_n` are already synchronous to `clk`. They also assume that each serial-clock level lasts at least one clock, and that `page_bin` changes only while `cs_n` is high. The bench meets these assumptions by changing every input on the falling edge of `clk`. It holds each serial-clock level for two clocks, and it sets the geometry before each command starts. The random commands use any 24-bit address, either geometry and either read command, with short bursts. Directed cases drive the column and page boundaries, an unknown command byte and an abort in the middle of a byte.

// File: rtl/frd_pkg.sv
package frd_pkg;

  typedef enum logic [2:0] {PH_OPC, PH_ADR, PH_PAD, PH_OUT, PH_IGN} phase_t;

  localparam logic [7:0] OPC_STREAM = 8'h03;
  localparam logic [7:0] OPC_PAGE   = 8'hD2;
  localparam int unsigned LONG_PAGE = 264;

  typedef struct packed {
    logic [31:0] page;
    logic [8:0]  col;
  } pos_t;

  // Fill value of the array at a linear index.
  function automatic logic [7:0] fill_byte(input logic [31:0] idx);
    logic [31:0] t;
    t = idx * 32'd7 + (idx >> 8);
    return t[7:0] ^ 8'hC3;
  endfunction

  // Last column of a page for the selected geometry.
  function automatic logic [8:0] last_col(input logic bin);
    return bin ? 9'd255 : 9'd263;
  endfunction

  // Split the low 20 address bits into a start page and a start column.
  function automatic pos_t first_pos(input logic [19:0] a, input logic bin,
                                     input int unsigned pages);
    pos_t r;
    if (bin) begin
      r.page = {21'd0, a[18:8]} % pages;
      r.col  = {1'b0, a[7:0]};
    end else begin
      r.page = {21'd0, a[19:9]} % pages;
      r.col  = (a[8:0] >= 9'd264) ? a[8:0] - 9'd264 : a[8:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/frd_array.sv
module frd_array #(
  parameter int PAGES = 4,
  localparam int DEPTH = PAGES * frd_pkg::LONG_PAGE,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data
);
  import frd_pkg::*;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= fill_byte(32'(i));
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/frd_seq.sv
module frd_seq
  import frd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck_rise,
  input  logic        si,
  output phase_t      phase,
  output logic        stream,
  output logic        load,
  output logic [19:0] load_addr
);

  logic [4:0]  cnt;
  logic [18:0] sr;
  logic [7:0]  op_word;

  assign op_word   = {sr[6:0], si};
  assign load_addr = {sr[18:0], si};
  assign load      = !cs_n && sck_rise && (phase == PH_ADR) && (cnt == 5'd23);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_OPC;
      cnt    <= '0;
      sr     <= '0;
      stream <= 1'b0;
    end else if (cs_n) begin
      phase <= PH_OPC;
      cnt   <= '0;
    end else if (sck_rise) begin
      case (phase)
        PH_OPC: begin
          sr <= {sr[17:0], si};
          if (cnt == 5'd7) begin
            cnt <= '0;
            if (op_word == OPC_STREAM) begin
              phase  <= PH_ADR;
              stream <= 1'b1;
            end else if (op_word == OPC_PAGE) begin
              phase  <= PH_ADR;
              stream <= 1'b0;
            end else begin
              phase <= PH_IGN;
            end
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
        PH_ADR: begin
          sr <= {sr[17:0], si};
          if (cnt == 5'd23) begin
            cnt   <= '0;
            phase <= stream ? PH_OUT : PH_PAD;
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
        PH_PAD: begin
          if (cnt == 5'd31) begin
            cnt   <= '0;
            phase <= PH_OUT;
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
        default: ;
      endcase
    end
  end

  // The page command reaches data only through the padding phase.
  assert_pad_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phase == PH_OUT) && !stream) |-> ($past(phase) == PH_PAD && $past(cnt) == 5'd31));

  // The stream command goes straight from address to data.
  assert_no_pad_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phase == PH_OUT) && stream) |-> ($past(phase) == PH_ADR && $past(cnt) == 5'd23));

endmodule

// File: rtl/frd_cursor.sv
module frd_cursor #(
  parameter int PAGES = 4,
  localparam int DEPTH = PAGES * frd_pkg::LONG_PAGE,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bin,
  input  logic          stream,
  input  logic          load,
  input  logic [19:0]   load_addr,
  input  logic          adv,
  output logic [IW-1:0] idx
);
  import frd_pkg::*;

  localparam logic [PW-1:0] TOP_PAGE = PW'(PAGES - 1);
  localparam logic [IW-1:0] STRIDE   = IW'(LONG_PAGE);

  logic [PW-1:0] page_q;
  logic [8:0]    col_q;
  logic          at_end;
  pos_t          start;

  assign start  = first_pos(load_addr, bin, PAGES);
  assign at_end = (col_q == last_col(bin));
  assign idx    = IW'(page_q) * STRIDE + IW'(col_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      col_q  <= '0;
    end else if (load) begin
      page_q <= PW'(start.page);
      col_q  <= start.col;
    end else if (adv) begin
      if (at_end) begin
        col_q <= '0;
        if (stream) page_q <= (page_q == TOP_PAGE) ? '0 : page_q + PW'(1);
      end else begin
        col_q <= col_q + 9'd1;
      end
    end
  end

  assert_page_roll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && stream && at_end && page_q != TOP_PAGE)
      |=> (col_q == 9'd0 && page_q == PW'($past(page_q) + PW'(1))));

  assert_array_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && stream && at_end && page_q == TOP_PAGE)
      |=> (col_q == 9'd0 && page_q == '0));

  assert_page_circle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !stream && at_end) |=> (col_q == 9'd0 && $stable(page_q)));

endmodule

// File: rtl/frd_shift.sv
module frd_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck_fall,
  input  logic       out_phase,
  input  logic [7:0] rd_data,
  output logic       so_q,
  output logic       oe_q,
  output logic       adv
);

  logic [2:0] bitn;
  logic [6:0] hold;

  assign adv = !cs_n && sck_fall && out_phase && (bitn == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n || cs_n) begin
      so_q <= 1'b0;
      oe_q <= 1'b0;
      bitn <= '0;
      hold <= '0;
    end else if (sck_fall && out_phase) begin
      oe_q <= 1'b1;
      if (bitn == 3'd0) begin
        so_q <= rd_data[7];
        hold <= rd_data[6:0];
        bitn <= 3'd7;
      end else begin
        so_q <= hold[6];
        hold <= {hold[5:0], 1'b0};
        bitn <= bitn - 3'd1;
      end
    end
  end

  assert_so_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (so_q != $past(so_q)) |-> ($past(sck_fall) || $past(cs_n)));

  assert_oe_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> out_phase);

endmodule

// File: rtl/serial_flash_reader.sv
module serial_flash_reader #(
  parameter int PAGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic page_bin,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  import frd_pkg::*;

  localparam int DEPTH = PAGES * LONG_PAGE;
  localparam int IW = $clog2(DEPTH);

  logic          sck_q;
  logic          sck_rise;
  logic          sck_fall;
  phase_t        phase;
  logic          stream;
  logic          load;
  logic [19:0]   load_addr;
  logic          adv;
  logic [IW-1:0] idx;
  logic [7:0]    rd_data;
  logic          so_q;
  logic          oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign sck_rise = sck && !sck_q;
  assign sck_fall = !sck && sck_q;

  frd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .si(si),
    .phase(phase), .stream(stream), .load(load), .load_addr(load_addr)
  );

  frd_cursor #(.PAGES(PAGES)) u_cursor (
    .clk(clk), .rst_n(rst_n), .bin(page_bin), .stream(stream), .load(load),
    .load_addr(load_addr), .adv(adv), .idx(idx)
  );

  frd_array #(.PAGES(PAGES)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_data(rd_data)
  );

  frd_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_fall(sck_fall),
    .out_phase(phase == PH_OUT), .rd_data(rd_data),
    .so_q(so_q), .oe_q(oe_q), .adv(adv)
  );

  assign so    = so_q;
  assign so_oe = oe_q && !cs_n;

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> (phase == PH_OPC && !so_oe));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGN) |-> !so_oe);

endmodule

// File: tb/sim_serial_flash_reader.sv
module sim_serial_flash_reader;

  localparam int NPG = 4;
  localparam int STRIDE = 264;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic page_bin = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic so;
  logic so_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_flash_reader #(.PAGES(NPG)) u0 (
    .clk(clk), .rst_n(rst_n), .page_bin(page_bin), .cs_n(cs_n),
    .sck(sck), .si(si), .so(so), .so_oe(so_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R11 pattern, restated with integer arithmetic.
  function automatic int model_byte(input int pg, input int col);
    int lin;
    lin = pg * STRIDE + col;
    return ((lin * 7 + lin / 256) % 256) ^ 'hC3;
  endfunction

  function automatic int model_page(input int addr, input bit bin);
    return (bin ? (addr / 256) % 2048 : (addr / 512) % 2048) % NPG;
  endfunction

  function automatic int model_col(input int addr, input bit bin);
    int c;
    if (bin) return addr % 256;
    c = addr % 512;
    return (c >= 264) ? c - 264 : c;
  endfunction

  task automatic bit_io(input logic b, output logic o, output logic oe, output logic held);
    si = b;
    repeat (2) @(negedge clk);
    o = so;
    oe = so_oe;
    sck = 1'b1;
    repeat (2) @(negedge clk);
    held = (so === o);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, inout bit any_oe);
    logic o, oe, h;
    for (int i = 7; i >= 0; i--) begin
      bit_io(v[i], o, oe, h);
      if (oe) any_oe = 1'b1;
    end
  endtask

  task automatic read_byte(output logic [7:0] v, output bit oe_ok, output bit held_ok);
    logic o, oe, h;
    oe_ok = 1'b1;
    held_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'($urandom), o, oe, h);
      v[i] = o;
      if (!oe) oe_ok = 1'b0;
      if (!h) held_ok = 1'b0;
    end
  endtask

  task automatic start_cmd(input logic [7:0] op, input int addr, input bit bin,
                           input string req);
    bit any_oe;
    any_oe = 1'b0;
    page_bin = bin;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    send_byte(op, any_oe);
    send_byte(8'((addr >> 16) & 'hFF), any_oe);
    send_byte(8'((addr >> 8) & 'hFF), any_oe);
    send_byte(8'(addr & 'hFF), any_oe);
    if (op == 8'hD2)
      for (int k = 0; k < 4; k++) send_byte(8'($urandom), any_oe);
    check(!any_oe, req, "so_oe during command bits", int'(any_oe), 0);
  endtask

  task automatic end_cmd();
    cs_n = 1'b1;
    #1;
    check(so_oe == 1'b0, "R9", "so_oe after cs_n rise", int'(so_oe), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_txn(input logic [7:0] op, input int addr, input bit bin,
                         input int nbytes, input string req);
    int pg, col, lim;
    logic [7:0] v;
    bit oe_ok, held_ok;
    start_cmd(op, addr, bin, req);
    pg = model_page(addr, bin);
    col = model_col(addr, bin);
    lim = bin ? 256 : 264;
    for (int k = 0; k < nbytes; k++) begin
      read_byte(v, oe_ok, held_ok);
      check(v == 8'(model_byte(pg, col)), req, "data byte", int'(v), model_byte(pg, col));
      check(oe_ok, req, "so_oe during data", int'(oe_ok), 1);
      check(held_ok, "R8", "so held while sck high", int'(held_ok), 1);
      col++;
      if (col == lim) begin
        col = 0;
        if (op == 8'h03) pg = (pg + 1) % NPG;
      end
    end
    end_cmd();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the run completed");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(so_oe == 1'b0, "R9", "so_oe after reset", int'(so_oe), 0);
    check(so == 1'b0, "R8", "so after reset", int'(so), 0);

    // Directed corner cases
    run_txn(8'h03, 0, 1'b0, 4, "R11");
    run_txn(8'h03, 0, 1'b0, 2, "R1");
    run_txn(8'h03, (1 << 9) | 260, 1'b0, 8, "R5");
    run_txn(8'h03, (3 << 9) | 262, 1'b0, 4, "R6");
    run_txn(8'h03, (3 << 8) | 254, 1'b1, 4, "R6");
    run_txn(8'hD2, (2 << 9) | 261, 1'b0, 6, "R7");
    run_txn(8'hD2, (3 << 8) | 255, 1'b1, 3, "R7");
    run_txn(8'h03, (1 << 8) | 254, 1'b1, 4, "R4");
    run_txn(8'hD2, 0, 1'b0, 3, "R2");
    run_txn(8'h03, (6 << 9) | 300, 1'b0, 2, "R3");
    run_txn(8'h03, (2 << 9) | 511, 1'b0, 2, "R3");

    // R10: unknown command byte keeps the output quiet
    begin
      bit any_oe;
      repeat (2) @(negedge clk);
      cs_n = 1'b0;
      repeat (2) @(negedge clk);
      any_oe = 1'b0;
      send_byte(8'h0B, any_oe);
      for (int k = 0; k < 8; k++) begin
        send_byte(8'($urandom), any_oe);
        check(!any_oe, "R10", "so_oe after unknown command", int'(any_oe), 0);
      end
      end_cmd();
    end
    run_txn(8'h03, (1 << 9) | 5, 1'b0, 2, "R10");

    // R9: abort in the middle of a data byte
    begin
      logic [7:0] v;
      logic o, oe, h;
      bit oe_ok, held_ok;
      start_cmd(8'h03, (2 << 9) | 10, 1'b0, "R9");
      read_byte(v, oe_ok, held_ok);
      check(v == 8'(model_byte(2, 10)), "R9", "byte before abort", int'(v), model_byte(2, 10));
      for (int k = 0; k < 3; k++) bit_io(1'b0, o, oe, h);
      end_cmd();
    end
    run_txn(8'hD2, (1 << 9) | 100, 1'b0, 2, "R9");

    // Constrained random commands
    for (int t = 0; t < 40; t++) begin
      logic [7:0] op;
      int addr;
      bit bin;
      int n;
      op = ($urandom % 2 == 0) ? 8'h03 : 8'hD2;
      bin = 1'($urandom);
      addr = int'($urandom & 32'h00FF_FFFF);
      if ($urandom % 3 == 0) addr = (addr & ~'hFF) | (bin ? 'hFC : 'h00);
      if (!bin && $urandom % 3 == 0) addr = (addr & ~'h1FF) | 'h104;
      n = 1 + int'($urandom % 6);
      run_txn(op, addr, bin, n, (op == 8'h03) ? "R5" : "R7");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule